// File: doc/BRIEF.md
# Codec Link Receive Slot Splitter

This block sits on the receive side of a serial audio/modem codec link. It counts bit clocks from the rising edge of the frame sync and shifts in the serial input stream. It then cuts each frame into a 16-bit tag slot followed by twelve 20-bit data slots. From those slots it recovers several values: the codec-ready flag, the address echoed by a previous control register read, the control read data, the left and right record samples, a modem sample, a dedicated microphone sample and the general-purpose input status word. Each recovered value comes with a one-clock valid strobe.

The slot-request flags in slot 1 behave differently from the other fields. They are forwarded to the output framer in every frame, whatever the tag bits say, so the framer knows which output slots it must fill in the next frame. The two stereo request flags are merged into a single request. Any nonzero content in the reserved slots is flagged as a protocol error. The block runs entirely in the bit-clock domain.

Top module: `lnk_rx_demux`

## Requirements
- R1: A frame starts on the clock where `sync_i` is sampled high after being sampled low. The `sdata_i` bit sampled on that clock is bit 15 of slot 0. Slot 0 is 16 bits and slots 1 to 12 are 20 bits each, all sent MSB first, for 256 bits in total. A new sync rising edge inside a frame restarts the count. Input after bit 255 is ignored until the next rising edge.
- R2: `codec_ready_o` takes slot 0 bit 15 on the clock after the last tag bit and holds it until the next frame's tag slot ends.
- R3: Slot 1 bits 11 down to 2 are request flags for output slots 3 to 12, where bit 11 is slot 3 and 1 means a request. `out_req_o[i]` covers output slot i+3. The flags are loaded, and `out_req_stb_o` pulses, in every frame, whatever the value of tag bit 14.
- R4: The slot 3 and slot 4 flags (slot 1 bits 11 and 10) act as one stereo request. If either flag is set, both `out_req_o[0]` and `out_req_o[1]` are 1. If neither is set, both are 0.
- R5: `stat_addr_o` takes slot 1 bits 18 down to 12, and `stat_addr_stb_o` pulses, only when tag bit 14 is set.
- R6: Slots 2, 3, 4, 5, 6 and 12 each yield 16 bits from slot bits 19 down to 4; bits 3 down to 0 are ignored. Their tag bits are 13, 12, 11, 10, 9 and 3. The outputs are, in slot order: control data, left, right, modem, microphone and general-purpose input status.
- R7: A captured value and its strobe update on the clock after the last bit of its slot, and the strobe stays high for exactly one clock. If a slot's tag bit is clear, its output keeps its previous value and its strobe stays low.
- R8: If any of slots 7 to 11 holds a nonzero bit, `resv_err_o` pulses for one clock after the last bit of that slot. All-zero reserved slots raise no error.
- R9: While reset is low, and right after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller side |
| sdata_i | input | 1 | Serial input data from the codec |
| codec_ready_o | output | 1 | Codec ready flag from the last tag slot |
| stat_addr_o | output | 7 | Echoed control read address |
| stat_addr_stb_o | output | 1 | One-clock valid for stat_addr_o |
| ctrl_data_o | output | 16 | Control register read data |
| ctrl_stb_o | output | 1 | One-clock valid for ctrl_data_o |
| rec_left_o | output | 16 | Left record sample |
| rec_left_stb_o | output | 1 | One-clock valid for rec_left_o |
| rec_right_o | output | 16 | Right record sample |
| rec_right_stb_o | output | 1 | One-clock valid for rec_right_o |
| modem_o | output | 16 | Modem sample |
| modem_stb_o | output | 1 | One-clock valid for modem_o |
| mic_o | output | 16 | Microphone sample |
| mic_stb_o | output | 1 | One-clock valid for mic_o |
| gpi_o | output | 16 | General-purpose input status word |
| gpi_stb_o | output | 1 | One-clock valid for gpi_o |
| out_req_o | output | 10 | Output slot requests; bit i covers slot i+3 |
| out_req_stb_o | output | 1 | Pulses each frame when out_req_o is loaded |
| resv_err_o | output | 1 | Nonzero content seen in a reserved slot |

## Verification
The bench sends a frame with slot 1's tag cleared but request flags present. A design that gated the requests with that tag would drop them. It sets only one of the two stereo flags to catch a design that forwards the pair unmerged. It fills the low four bits of every data slot with ones, which exposes a field taken at the wrong offset. It records the bit index at which each strobe fires, which catches an off-by-one in slot timing. The bench also aborts a frame with an early sync edge, which a counter that ignores re-sync would misalign. Finally, it hides a single nonzero bit in the low end of one reserved slot, which a checker looking only at the upper field would miss.

// File: rtl/lnk_rx_pkg.sv
// Package: shared frame geometry for the codec link receive path.
// Assumes: one fixed frame layout; modules take these as parameter defaults.
package lnk_rx_pkg;
    localparam int TAG_W      = 16;  // slot 0 width
    localparam int SLOT_W     = 20;  // data slot width
    localparam int NUM_SLOTS  = 12;  // data slots per frame
    localparam int SMP_W      = 16;  // sample width taken from slot MSBs
    localparam int ADDR_W     = 7;   // echoed register address width
    localparam int NUM_REQ    = 10;  // request flags, slots 3..12
    localparam int RESV_FIRST = 7;
    localparam int RESV_LAST  = 11;
    localparam int NUM_DATA   = 6;   // captured 16-bit data slots
endpackage

// File: rtl/lnk_rx_timer.sv
// Module: lnk_rx_timer
// Detects the sync rising edge and tracks slot number and bit position
// for the bit being sampled this clock. Flags the last bit of every slot.
// Assumes: sync_i and the data are sampled on the same rising clk edge.
module lnk_rx_timer
    import lnk_rx_pkg::*;
#(
    parameter int TW = TAG_W,
    parameter int SW = SLOT_W,
    parameter int NS = NUM_SLOTS,
    localparam int POS_W = $clog2(SW),
    localparam int NUM_W = $clog2(NS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic             bit_vld_o,
    output logic             slot_end_o,
    output logic [NUM_W-1:0] slot_num_o
);
    localparam logic [POS_W-1:0] TAG_LAST  = POS_W'(TW - 1);
    localparam logic [POS_W-1:0] DAT_LAST  = POS_W'(SW - 1);
    localparam logic [NUM_W-1:0] LAST_SLOT = NUM_W'(NS);

    logic             sync_q, act_q, rise;
    logic [POS_W-1:0] pos_q, cur_pos, last_q, cur_last;
    logic [NUM_W-1:0] slot_q, cur_slot;
    logic             cur_act;

    // Next position for the bit sampled on this clock.
    always_comb begin
        rise     = sync_i & ~sync_q;
        last_q   = (slot_q == '0) ? TAG_LAST : DAT_LAST;
        cur_pos  = pos_q;
        cur_slot = slot_q;
        cur_act  = 1'b0;
        if (rise) begin
            cur_pos  = '0;
            cur_slot = '0;
            cur_act  = 1'b1;
        end else if (act_q && !(slot_q == LAST_SLOT && pos_q == DAT_LAST)) begin
            cur_act = 1'b1;
            if (pos_q == last_q) begin
                cur_pos  = '0;
                cur_slot = slot_q + 1'b1;
            end else begin
                cur_pos = pos_q + 1'b1;
            end
        end
        cur_last   = (cur_slot == '0) ? TAG_LAST : DAT_LAST;
        bit_vld_o  = cur_act;
        slot_end_o = cur_act && (cur_pos == cur_last);
        slot_num_o = cur_slot;
    end

    // Frame position state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            act_q  <= 1'b0;
            pos_q  <= '0;
            slot_q <= '0;
        end else begin
            sync_q <= sync_i;
            act_q  <= cur_act;
            pos_q  <= cur_pos;
            slot_q <= cur_slot;
        end
    end

    // R1: the position never leaves the frame geometry.
    p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (slot_q <= LAST_SLOT && pos_q <= last_q));
    // R1: a sync rising edge always restarts at slot 0, bit 0.
    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !sync_q) |=> (act_q && slot_q == '0 && pos_q == '0));
endmodule

// File: rtl/lnk_rx_shift.sv
// Module: lnk_rx_shift
// Serial-to-parallel register; word_o includes the bit sampled this clock,
// so a complete slot is visible on the clock of its last bit.
// Assumes: bit_vld_i is high for every bit inside a frame.
module lnk_rx_shift #(
    parameter int W = lnk_rx_pkg::SLOT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_vld_i,
    input  logic         sdata_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_q;

    // Word formed with the incoming bit at the LSB.
    always_comb word_o = {sh_q[W-2:0], sdata_i};

    // Shift one bit per frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         sh_q <= '0;
        else if (bit_vld_i) sh_q <= word_o;
    end

    // R1: bits enter MSB first, so the newest bit sits at the LSB.
    p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_i |=> (sh_q[0] == $past(sdata_i)));
endmodule

// File: rtl/lnk_rx_capture.sv
// Module: lnk_rx_capture
// Latches the tag slot, slot 1 fields, the six 16-bit data slots and the
// reserved-slot check at the end of each slot. Strobes last one clock.
// Assumes: slot_end_i pulses once per slot, with slot_num_i valid.
module lnk_rx_capture
    import lnk_rx_pkg::*;
#(
    parameter int TW = TAG_W,
    parameter int SW = SLOT_W,
    parameter int NS = NUM_SLOTS,
    parameter int DW = SMP_W,
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REQ,
    parameter int ND = NUM_DATA,
    localparam int NUM_W = $clog2(NS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_end_i,
    input  logic [NUM_W-1:0]     slot_num_i,
    input  logic [SW-1:0]        word_i,
    output logic                 ready_o,
    output logic [AW-1:0]        addr_o,
    output logic                 addr_stb_o,
    output logic [ND-1:0][DW-1:0] data_o,
    output logic [ND-1:0]        data_stb_o,
    output logic [NR-1:0]        req_o,
    output logic                 req_stb_o,
    output logic                 resv_err_o
);
    // Slot number of each captured data channel, in output order.
    localparam int DSLOT [ND] = '{2, 3, 4, 5, 6, 12};

    logic [TW-1:0]   tag_q;
    logic [NR-1:0]   raw_req, req_n;
    logic            end_tag, end_s1, in_resv;

    // Slot decode and request remapping with stereo merge.
    always_comb begin
        end_tag = slot_end_i && (slot_num_i == '0);
        end_s1  = slot_end_i && (slot_num_i == NUM_W'(1));
        in_resv = slot_end_i && (slot_num_i >= NUM_W'(RESV_FIRST))
                             && (slot_num_i <= NUM_W'(RESV_LAST));
        raw_req = word_i[SW-2-AW -: NR];
        for (int i = 0; i < NR; i++) req_n[i] = raw_req[NR-1-i];
        req_n[0] = raw_req[NR-1] | raw_req[NR-2];
        req_n[1] = req_n[0];
    end

    // Tag slot, slot 1 fields and reserved-slot check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q      <= '0;
            ready_o    <= 1'b0;
            addr_o     <= '0;
            addr_stb_o <= 1'b0;
            req_o      <= '0;
            req_stb_o  <= 1'b0;
            resv_err_o <= 1'b0;
        end else begin
            addr_stb_o <= 1'b0;
            req_stb_o  <= 1'b0;
            resv_err_o <= in_resv && (word_i != '0);
            if (end_tag) begin
                tag_q   <= word_i[TW-1:0];
                ready_o <= word_i[TW-1];
            end
            if (end_s1) begin
                req_o     <= req_n;
                req_stb_o <= 1'b1;
                if (tag_q[TW-2]) begin
                    addr_o     <= word_i[SW-2 -: AW];
                    addr_stb_o <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < ND; g++) begin : g_chan
        logic hit;
        // Channel hit: end of its slot with its tag set.
        always_comb hit = slot_end_i && (slot_num_i == NUM_W'(DSLOT[g]))
                          && tag_q[TW-1-DSLOT[g]];

        // Channel latch and strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[g]     <= '0;
                data_stb_o[g] <= 1'b0;
            end else begin
                data_stb_o[g] <= hit;
                if (hit) data_o[g] <= word_i[SW-1 -: DW];
            end
        end

        // R7: a strobe never lasts past one clock.
        p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            data_stb_o[g] |=> !data_stb_o[g]);
        // R7: a held value only moves together with its strobe.
        p_hold_untagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(data_o[g]) |-> data_stb_o[g]);
    end

    // R3: requests are forwarded on every slot 1 end, tag or not.
    p_req_every_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        end_s1 |=> req_stb_o);
    // R5: address strobe only ever coincides with the request strobe.
    p_addr_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |-> req_stb_o);
    // R7: different slots never strobe together.
    p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_stb_o, req_stb_o, resv_err_o}));
    // R4: the stereo pair is always forwarded as one request.
    p_stereo_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_stb_o |-> (req_o[0] == req_o[1]));
endmodule

// File: rtl/lnk_rx_demux.sv
// Module: lnk_rx_demux (top)
// Receive-side frame splitter of a serial codec link: timing, shifting and
// slot capture, with each data channel brought out on its own ports.
// Assumes: one clock domain, the link bit clock.
module lnk_rx_demux
    import lnk_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_i,
    input  logic                 sdata_i,
    output logic                 codec_ready_o,
    output logic [ADDR_W-1:0]    stat_addr_o,
    output logic                 stat_addr_stb_o,
    output logic [SMP_W-1:0]     ctrl_data_o,
    output logic                 ctrl_stb_o,
    output logic [SMP_W-1:0]     rec_left_o,
    output logic                 rec_left_stb_o,
    output logic [SMP_W-1:0]     rec_right_o,
    output logic                 rec_right_stb_o,
    output logic [SMP_W-1:0]     modem_o,
    output logic                 modem_stb_o,
    output logic [SMP_W-1:0]     mic_o,
    output logic                 mic_stb_o,
    output logic [SMP_W-1:0]     gpi_o,
    output logic                 gpi_stb_o,
    output logic [NUM_REQ-1:0]   out_req_o,
    output logic                 out_req_stb_o,
    output logic                 resv_err_o
);
    localparam int NUM_W = $clog2(NUM_SLOTS + 1);

    logic                          bit_vld, slot_end;
    logic [NUM_W-1:0]              slot_num;
    logic [SLOT_W-1:0]             word;
    logic [NUM_DATA-1:0][SMP_W-1:0] data;
    logic [NUM_DATA-1:0]           data_stb;

    lnk_rx_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .bit_vld_o  (bit_vld),
        .slot_end_o (slot_end),
        .slot_num_o (slot_num)
    );

    lnk_rx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld_i (bit_vld),
        .sdata_i   (sdata_i),
        .word_o    (word)
    );

    lnk_rx_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_end_i (slot_end),
        .slot_num_i (slot_num),
        .word_i     (word),
        .ready_o    (codec_ready_o),
        .addr_o     (stat_addr_o),
        .addr_stb_o (stat_addr_stb_o),
        .data_o     (data),
        .data_stb_o (data_stb),
        .req_o      (out_req_o),
        .req_stb_o  (out_req_stb_o),
        .resv_err_o (resv_err_o)
    );

    // Fan the channel array out to named ports.
    always_comb begin
        ctrl_data_o     = data[0];  ctrl_stb_o      = data_stb[0];
        rec_left_o      = data[1];  rec_left_stb_o  = data_stb[1];
        rec_right_o     = data[2];  rec_right_stb_o = data_stb[2];
        modem_o         = data[3];  modem_stb_o     = data_stb[3];
        mic_o           = data[4];  mic_stb_o       = data_stb[4];
        gpi_o           = data[5];  gpi_stb_o       = data_stb[5];
    end
endmodule

// File: tb/tb_lnk_rx_demux.sv
module tb_lnk_rx_demux;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic sdata_i = 1'b0;
    logic        codec_ready_o, stat_addr_stb_o, ctrl_stb_o, rec_left_stb_o;
    logic        rec_right_stb_o, modem_stb_o, mic_stb_o, gpi_stb_o;
    logic        out_req_stb_o, resv_err_o;
    logic [6:0]  stat_addr_o;
    logic [15:0] ctrl_data_o, rec_left_o, rec_right_o, modem_o, mic_o, gpi_o;
    logic [9:0]  out_req_o;

    always #5 clk = ~clk;

    lnk_rx_demux dut (.*);

    int n_chk = 0, n_bad = 0;
    int cur_bit = -1;
    int sc [9];
    int sp [9];
    logic [19:0] frm [13];
    bit done = 0;

    // Event index: 0 addr,1 ctrl,2 left,3 right,4 modem,5 mic,6 gpi,7 req,8 resv
    localparam int EPOS [8] = '{35, 55, 75, 95, 115, 135, 255, 35};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record strobes 3 ns after each rising edge, with the bit just sampled.
    always @(posedge clk) begin
        logic [8:0] ev;
        #3;
        ev = {resv_err_o, out_req_stb_o, gpi_stb_o, mic_stb_o, modem_stb_o,
              rec_right_stb_o, rec_left_stb_o, ctrl_stb_o, stat_addr_stb_o};
        for (int i = 0; i < 9; i++) if (ev[i]) begin sc[i]++; sp[i] = cur_bit; end
    end

    function automatic logic [9:0] exp_req(input logic [9:0] raw);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = raw[9-i];
        r[0] = raw[9] | raw[8];
        r[1] = r[0];
        return r;
    endfunction

    function automatic logic [19:0] s1_word(input logic [6:0] a, input logic [9:0] rq);
        return {1'b0, a, rq, 2'b00};
    endfunction

    // Drive nbits of a frame from tag and frm[]; then idle a few clocks.
    task automatic send(input logic [15:0] tag, input int nbits);
        logic [255:0] bits;
        bits[255:240] = tag;
        for (int k = 1; k <= 12; k++) bits[255-16-20*(k-1) -: 20] = frm[k];
        for (int i = 0; i < 9; i++) begin sc[i] = 0; sp[i] = -1; end
        for (int n = 0; n < nbits; n++) begin
            @(negedge clk);
            cur_bit = n;
            sync_i  = (n < 16);
            sdata_i = bits[255-n];
        end
        if (nbits == 256) begin
            @(negedge clk);
            cur_bit = 999; sync_i = 0; sdata_i = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R9 ready", codec_ready_o, 0);
        chk("R9 addr", stat_addr_o, 0);
        chk("R9 data", {ctrl_data_o, rec_left_o} | {gpi_o, mic_o}, 0);
        chk("R9 req", out_req_o, 0);
        chk("R9 strobes", {stat_addr_stb_o, ctrl_stb_o, gpi_stb_o, out_req_stb_o, resv_err_o}, 0);
    endtask

    task automatic t_full;
        frm[1] = s1_word(7'h5A, 10'b10_1100_1010);
        for (int k = 2; k <= 12; k++) frm[k] = 0;
        frm[2] = 20'h1234F; frm[3] = 20'hA5A5F; frm[4] = 20'h5A5AF;
        frm[5] = 20'hBEEFF; frm[6] = 20'hC0DEF; frm[12] = 20'h8001F;
        send(16'hFFF8, 256);
        chk("R2 ready set", codec_ready_o, 1);
        chk("R5 addr", stat_addr_o, 7'h5A);
        chk("R6 ctrl", ctrl_data_o, 16'h1234);
        chk("R6 left", rec_left_o, 16'hA5A5);
        chk("R6 right", rec_right_o, 16'h5A5A);
        chk("R6 modem", modem_o, 16'hBEEF);
        chk("R6 mic", mic_o, 16'hC0DE);
        chk("R6 gpi", gpi_o, 16'h8001);
        chk("R3 req", out_req_o, exp_req(10'b10_1100_1010));
        for (int i = 0; i < 8; i++) begin
            chk($sformatf("R7 count ev%0d", i), sc[i], 1);
            chk($sformatf("R1 timing ev%0d", i), sp[i], EPOS[i]);
        end
        chk("R8 no err", sc[8], 0);
    endtask

    task automatic t_untagged;
        frm[1] = s1_word(7'h11, 10'b00_0000_0101);
        frm[2] = 20'h99990; frm[3] = 20'h77770; frm[4] = 20'h66660;
        frm[5] = 20'h55550; frm[6] = 20'h44440; frm[12] = 20'h33330;
        send(16'h8000 | 16'h1000, 256);
        chk("R5 addr held", stat_addr_o, 7'h5A);
        chk("R5 no addr stb", sc[0], 0);
        chk("R3 req without tag", out_req_o, exp_req(10'b00_0000_0101));
        chk("R3 req stb", sc[7], 1);
        chk("R7 left updated", rec_left_o, 16'h7777);
        chk("R7 ctrl held", ctrl_data_o, 16'h1234);
        chk("R7 gpi held", gpi_o, 16'h8001);
        chk("R7 right no stb", sc[3], 0);
        chk("R7 mic no stb", sc[5], 0);
    endtask

    task automatic t_stereo;
        frm[1] = s1_word(7'h00, 10'b01_0000_0000);
        send(16'h8000, 256);
        chk("R4 slot4 flag only", out_req_o[1:0], 2'b11);
        frm[1] = s1_word(7'h00, 10'b10_0000_0000);
        send(16'h8000, 256);
        chk("R4 slot3 flag only", out_req_o[1:0], 2'b11);
        frm[1] = s1_word(7'h00, 10'b00_1000_0001);
        send(16'h8000, 256);
        chk("R4 no stereo", out_req_o[1:0], 2'b00);
        chk("R3 slot5 and slot12", out_req_o, 10'b10_0000_0100);
    endtask

    task automatic t_reserved;
        for (int k = 1; k <= 12; k++) frm[k] = 0;
        frm[9] = 20'h00008;
        send(16'h0000, 256);
        chk("R8 err count", sc[8], 1);
        chk("R8 err timing", sp[8], 195);
        chk("R2 ready clear", codec_ready_o, 0);
        frm[9] = 0;
        send(16'h0000, 256);
        chk("R8 zeros no err", sc[8], 0);
    endtask

    task automatic t_restart;
        for (int k = 1; k <= 12; k++) frm[k] = 20'hFFFFF;
        send(16'hFFF8, 50);
        frm[1] = s1_word(7'h2C, 10'b0);
        for (int k = 2; k <= 12; k++) frm[k] = 0;
        frm[6] = 20'h13570;
        send(16'hFFF8, 256);
        chk("R1 restart addr", stat_addr_o, 7'h2C);
        chk("R1 restart mic", mic_o, 16'h1357);
        chk("R1 restart timing", sp[5], 135);
        chk("R1 restart req", out_req_o, 0);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_full;
        t_untagged;
        t_stereo;
        t_reserved;
        t_restart;
        finish_up;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up;
    end
endmodule